// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the software-visible register layer of an SMBus host controller. A simple byte-wide memory-mapped port writes and reads it, with registers placed every 8 bytes. It holds the transfer setup: command byte, target address with direction flag, two data bytes, protocol selection and auxiliary enables. It passes that setup, together with a start pulse and a kill level, to a separate transaction engine. The engine reports completion and error events back. The block folds these events into a status register. The status bits stay set until software writes a one to them.

Software loads the setup registers and then writes the control register with the start bit and a protocol code. The host-busy flag marks the transfer in flight. When busy falls, software reads the status bits to tell a clean finish, a missing acknowledge, lost arbitration and an abort apart. The kill bit lets software abort a transfer that hangs.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every mapped register (status 0x00, control 0x10, command 0x18, address 0x20, data0 0x28, data1 0x30, aux control 0x68) reads zero, and start, kill, PEC, CRC and buffer-enable outputs are low.
- R2: Command, address, data0 and data1 read back what was last written and drive their engine outputs. Address bits [7:1] form the 7-bit target address and bit 0 the read flag. Any offset that is not one of the mapped offsets (including offsets that are not a multiple of 8) reads zero and ignores writes.
- R3: A control write with bit 6 set, bit 1 clear and host busy clear produces a one-cycle start pulse on the clock edge that takes the write. Host busy (status bit 0) is set from the same edge. The protocol output follows control bits [4:2] and the PEC output follows bit 7. Bit 6 reads back as zero.
- R4: A start written while host busy is set produces no start pulse.
- R5: A done indication while busy, with no error in the same cycle, clears host busy and sets the interrupt flag (status bit 1).
- R6: A device error (status bit 2) or bus error (status bit 3) while busy sets its flag and clears host busy. The interrupt flag is not set, even when done arrives in the same cycle.
- R7: A byte-done indication while busy sets status bit 7 and leaves host busy set.
- R8: Status bits 7, 4, 3, 2 and 1 are sticky. Writing a one to a bit clears it, and writing a zero leaves it as it is. Host busy cannot be changed by a status write.
- R9: Control bit 1 is a stored kill level that reads back and drives the kill output. While it is set and host busy is set, the next edge clears host busy and sets the failed flag (status bit 4).
- R10: Aux control bit 0 drives the CRC enable and bit 1 the block buffer enable. Both read back as written, and the other bits of that register read zero.
- R11: Done, error and byte-done indications that arrive while host busy is clear change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (7) | Byte offset of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| eng_start_o | output | 1 | One-cycle transfer launch |
| eng_kill_o | output | 1 | Abort request level |
| eng_proto_o | output | 3 | Protocol code, control bits [4:2] |
| eng_pec_o | output | 1 | Packet error checking requested |
| eng_cmd_o | output | 8 | Command byte |
| eng_slv_addr_o | output | 7 | Target address |
| eng_rnw_o | output | 1 | Read flag |
| eng_data0_o | output | 8 | First data byte |
| eng_data1_o | output | 8 | Second data byte |
| eng_crc_en_o | output | 1 | Hardware CRC enable |
| eng_blkbuf_en_o | output | 1 | Block buffer enable |
| eng_done_i | input | 1 | Engine finished the transfer |
| eng_dev_err_i | input | 1 | No acknowledge from target |
| eng_bus_err_i | input | 1 | Arbitration lost |
| eng_byte_done_i | input | 1 | One byte moved |

## Verification
Directed sequences run each engine outcome in turn: a clean done, a device error with a simultaneous done, a bus error, byte-done with busy held, and a kill. These separate the error-over-done priority from the plain completion path and from the abort path. Writes of zero, of one to the busy bit and of one to a single sticky bit show whether clearing is really per bit. Engine pulses while idle, and a start while busy, show that the busy flag gates both sides. A seeded random mix of starts, status writes and engine events then runs against a bench model, mainly to exercise events that coincide in the same cycle.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int DW = 8;
  localparam int IDX_STS  = 0;
  localparam int IDX_CTL  = 2;
  localparam int IDX_CMD  = 3;
  localparam int IDX_ADR  = 4;
  localparam int IDX_D0   = 5;
  localparam int IDX_D1   = 6;
  localparam int IDX_AUXC = 13;

  localparam int CT_KILL  = 1;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  localparam logic [DW-1:0] STS_W1C = 8'h9E;

  typedef struct packed {
    logic byte_done;
    logic in_use;
    logic alert;
    logic failed;
    logic bus_err;
    logic dev_err;
    logic intr;
    logic busy;
  } sts_t;
endpackage

// File: rtl/smb_addr_dec.sv
module smb_addr_dec #(
  parameter int ADDR_W      = 7,
  parameter int STRIDE_LOG2 = 3
) (
  input  logic [ADDR_W-1:0]                    addr_i,
  output logic [(1<<(ADDR_W-STRIDE_LOG2))-1:0] sel_o
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;
  localparam int N_IDX = 1 << IDX_W;

  logic aligned;
  assign aligned = (addr_i[STRIDE_LOG2-1:0] == '0);

  for (genvar i = 0; i < N_IDX; i++) begin : g_sel
    assign sel_o[i] = aligned && (addr_i[ADDR_W-1:STRIDE_LOG2] == IDX_W'(i));
  end
endmodule

// File: rtl/smb_rw_reg.sv
module smb_rw_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/smb_ctrl_reg.sv
module smb_ctrl_reg
  import smb_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic          start_fire_o,
  output logic          start_o,
  output logic          kill_o,
  output logic [2:0]    proto_o,
  output logic          pec_o,
  output logic [DW-1:0] rd_o
);
  // kill in the same write suppresses launch
  assign start_fire_o = wr_i && wdata_i[CT_START] && !wdata_i[CT_KILL] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      kill_o  <= 1'b0;
      proto_o <= '0;
      pec_o   <= 1'b0;
    end else begin
      start_o <= start_fire_o;
      if (wr_i) begin
        kill_o  <= wdata_i[CT_KILL];
        proto_o <= wdata_i[4:2];
        pec_o   <= wdata_i[CT_PEC];
      end
    end
  end

  assign rd_o = {pec_o, 2'b00, proto_o, kill_o, 1'b0};
endmodule

// File: rtl/smb_status_reg.sv
module smb_status_reg
  import smb_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_fire_i,
  input  logic          kill_i,
  input  logic [DW-1:0] clr_i,
  input  logic          done_i,
  input  logic          dev_err_i,
  input  logic          bus_err_i,
  input  logic          byte_done_i,
  output sts_t          sts_o
);
  sts_t sts_q;
  logic ends;

  assign ends = sts_q.busy && (done_i || dev_err_i || bus_err_i || kill_i);

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else begin
      if (start_fire_i) sts_q.busy <= 1'b1;
      else if (ends)    sts_q.busy <= 1'b0;
      sts_q.intr      <= (sts_q.intr && !clr_i[1]) ||
                         (sts_q.busy && done_i && !dev_err_i && !bus_err_i);
      sts_q.dev_err   <= (sts_q.dev_err && !clr_i[2]) || (sts_q.busy && dev_err_i);
      sts_q.bus_err   <= (sts_q.bus_err && !clr_i[3]) || (sts_q.busy && bus_err_i);
      sts_q.failed    <= (sts_q.failed && !clr_i[4]) || (sts_q.busy && kill_i);
      sts_q.byte_done <= (sts_q.byte_done && !clr_i[7]) || (sts_q.busy && byte_done_i);
      sts_q.alert     <= 1'b0;
      sts_q.in_use    <= 1'b0;
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_regs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int STRIDE_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              eng_start_o,
  output logic              eng_kill_o,
  output logic [2:0]        eng_proto_o,
  output logic              eng_pec_o,
  output logic [7:0]        eng_cmd_o,
  output logic [6:0]        eng_slv_addr_o,
  output logic              eng_rnw_o,
  output logic [7:0]        eng_data0_o,
  output logic [7:0]        eng_data1_o,
  output logic              eng_crc_en_o,
  output logic              eng_blkbuf_en_o,
  input  logic              eng_done_i,
  input  logic              eng_dev_err_i,
  input  logic              eng_bus_err_i,
  input  logic              eng_byte_done_i
);
  localparam int N_IDX = 1 << (ADDR_W - STRIDE_LOG2);

  logic [N_IDX-1:0] sel;
  logic [N_IDX-1:0] wr;
  logic [DW-1:0]    clr;
  logic [DW-1:0]    ctl_rd, adr_q;
  logic [1:0]       aux_q;
  logic             start_fire;
  sts_t             sts;

  smb_addr_dec #(.ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)) u_dec (
    .addr_i(addr_i), .sel_o(sel)
  );

  assign wr  = we_i ? sel : '0;
  assign clr = wr[IDX_STS] ? (wdata_i & STS_W1C) : '0;

  smb_ctrl_reg u_ctl (
    .clk_i, .rst_ni,
    .wr_i(wr[IDX_CTL]), .wdata_i, .busy_i(sts.busy),
    .start_fire_o(start_fire), .start_o(eng_start_o), .kill_o(eng_kill_o),
    .proto_o(eng_proto_o), .pec_o(eng_pec_o), .rd_o(ctl_rd)
  );

  smb_status_reg u_sts (
    .clk_i, .rst_ni,
    .start_fire_i(start_fire), .kill_i(eng_kill_o), .clr_i(clr),
    .done_i(eng_done_i), .dev_err_i(eng_dev_err_i), .bus_err_i(eng_bus_err_i),
    .byte_done_i(eng_byte_done_i), .sts_o(sts)
  );

  smb_rw_reg #(.W(DW)) u_cmd (.clk_i, .rst_ni, .we_i(wr[IDX_CMD]), .d_i(wdata_i), .q_o(eng_cmd_o));
  smb_rw_reg #(.W(DW)) u_adr (.clk_i, .rst_ni, .we_i(wr[IDX_ADR]), .d_i(wdata_i), .q_o(adr_q));
  smb_rw_reg #(.W(DW)) u_d0  (.clk_i, .rst_ni, .we_i(wr[IDX_D0]),  .d_i(wdata_i), .q_o(eng_data0_o));
  smb_rw_reg #(.W(DW)) u_d1  (.clk_i, .rst_ni, .we_i(wr[IDX_D1]),  .d_i(wdata_i), .q_o(eng_data1_o));
  smb_rw_reg #(.W(2))  u_aux (.clk_i, .rst_ni, .we_i(wr[IDX_AUXC]), .d_i(wdata_i[1:0]), .q_o(aux_q));

  assign eng_slv_addr_o  = adr_q[7:1];
  assign eng_rnw_o       = adr_q[0];
  assign eng_crc_en_o    = aux_q[0];
  assign eng_blkbuf_en_o = aux_q[1];

  always_comb begin
    rdata_o = '0;
    if (sel[IDX_STS])  rdata_o = sts;
    if (sel[IDX_CTL])  rdata_o = ctl_rd;
    if (sel[IDX_CMD])  rdata_o = eng_cmd_o;
    if (sel[IDX_ADR])  rdata_o = adr_q;
    if (sel[IDX_D0])   rdata_o = eng_data0_o;
    if (sel[IDX_D1])   rdata_o = eng_data1_o;
    if (sel[IDX_AUXC]) rdata_o = {6'b0, aux_q};
  end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              eng_start_o,
  input logic              eng_kill_o,
  input logic              eng_done_i,
  input logic              eng_dev_err_i,
  input logic              eng_bus_err_i,
  input logic              busy_i,
  input logic              intr_i,
  input logic              failed_i
);
  logic sts_clr_intr;
  assign sts_clr_intr = we_i && (addr_i == '0) && wdata_i[1];

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> busy_i);
  p_no_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !eng_start_o);
  p_done_intr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && eng_done_i && !eng_dev_err_i && !eng_bus_err_i |=> intr_i && !busy_i);
  p_err_no_intr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !intr_i && (eng_dev_err_i || eng_bus_err_i) |=> !intr_i && !busy_i);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_i && !sts_clr_intr |=> intr_i);
  p_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && eng_kill_o |=> !busy_i && failed_i);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !intr_i |=> !intr_i);
endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .eng_start_o(eng_start_o), .eng_kill_o(eng_kill_o), .eng_done_i(eng_done_i),
  .eng_dev_err_i(eng_dev_err_i), .eng_bus_err_i(eng_bus_err_i),
  .busy_i(sts.busy), .intr_i(sts.intr), .failed_i(sts.failed)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic we;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;
  logic start, kill, pec, rnw, crc_en, buf_en;
  logic [2:0] proto;
  logic [7:0] cmd, d0, d1;
  logic [6:0] slv;
  logic done, dev, bus, bdone;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .eng_start_o(start), .eng_kill_o(kill), .eng_proto_o(proto), .eng_pec_o(pec),
    .eng_cmd_o(cmd), .eng_slv_addr_o(slv), .eng_rnw_o(rnw), .eng_data0_o(d0), .eng_data1_o(d1),
    .eng_crc_en_o(crc_en), .eng_blkbuf_en_o(buf_en),
    .eng_done_i(done), .eng_dev_err_i(dev), .eng_bus_err_i(bus), .eng_byte_done_i(bdone)
  );

  int checks = 0;
  int errors = 0;

  // bench model
  logic m_busy, m_intr, m_dev, m_bus, m_fail, m_byte, m_kill;
  logic [7:0] m_ctl;
  logic [7:0] m_rw [0:15];

  function automatic logic [7:0] exp_sts();
    return {m_byte, 2'b00, m_fail, m_bus, m_dev, m_intr, m_busy};
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a[2:0] != 3'd0) return 8'h00;
    case (a >> 3)
      0:       return exp_sts();
      2:       return m_ctl;
      3, 4, 5, 6, 13: return m_rw[a >> 3];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input int a, input logic [7:0] d,
                      input logic dn, input logic de, input logic bu, input logic by,
                      input string tag);
    logic cw, fire;
    logic [7:0] clr;
    we = w; addr = AW'(a); wdata = d; done = dn; dev = de; bus = bu; bdone = by;
    @(posedge clk);
    cw   = w && (a == 16);
    fire = cw && d[6] && !d[1] && !m_busy;
    clr  = (w && a == 0) ? (d & 8'h9E) : 8'h00;
    m_intr = (m_intr & ~clr[1]) | (m_busy & dn & ~de & ~bu);
    m_dev  = (m_dev  & ~clr[2]) | (m_busy & de);
    m_bus  = (m_bus  & ~clr[3]) | (m_busy & bu);
    m_fail = (m_fail & ~clr[4]) | (m_busy & m_kill);
    m_byte = (m_byte & ~clr[7]) | (m_busy & by);
    if (fire) m_busy = 1'b1;
    else if (m_busy && (dn || de || bu || m_kill)) m_busy = 1'b0;
    if (cw) begin
      m_kill = d[1];
      m_ctl  = {d[7], 2'b00, d[4:2], d[1], 1'b0};
    end
    if (w && a[2:0] == 3'd0 && (a >> 3) inside {3, 4, 5, 6})
      m_rw[a >> 3] = d;
    if (w && a == 104) m_rw[13] = {6'b0, d[1:0]};
    @(negedge clk);
    we = 0; done = 0; dev = 0; bus = 0; bdone = 0; addr = '0; wdata = '0;
    #1;
    chk({tag, " status"}, rdata, exp_sts());
    chk({tag, " start"}, {7'b0, start}, {7'b0, fire});
    chk({tag, " kill"}, {7'b0, kill}, {7'b0, m_kill});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 8'h00, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    addr = AW'(a);
    #1;
    chk(tag, rdata, exp_rd(a));
    addr = '0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; we = 0; addr = '0; wdata = '0; done = 0; dev = 0; bus = 0; bdone = 0;
    m_busy = 0; m_intr = 0; m_dev = 0; m_bus = 0; m_fail = 0; m_byte = 0; m_kill = 0;
    m_ctl = 0;
    for (int i = 0; i < 16; i++) m_rw[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;

    // R1 reset state
    foreach (m_rw[i]) rd(i * 8, "R1 reset read");
    chk("R1 outputs", {start, kill, pec, crc_en, buf_en, 3'b0}, 8'h00);

    // R2 readback and address split
    step(1, 24, 8'hA5, 0, 0, 0, 0, "R2");
    step(1, 32, 8'h6B, 0, 0, 0, 0, "R2");
    step(1, 40, 8'h3C, 0, 0, 0, 0, "R2");
    step(1, 48, 8'hC3, 0, 0, 0, 0, "R2");
    rd(24, "R2 cmd"); rd(32, "R2 addr"); rd(40, "R2 data0"); rd(48, "R2 data1");
    chk("R2 cmd out", cmd, 8'hA5);
    chk("R2 slave addr", {1'b0, slv}, 8'h35);
    chk("R2 rnw", {7'b0, rnw}, 8'h01);
    chk("R2 data outs", d0 ^ d1, 8'hFF);
    step(1, 56, 8'hFF, 0, 0, 0, 0, "R2 unmapped write");
    step(1, 41, 8'hFF, 0, 0, 0, 0, "R2 misaligned write");
    rd(56, "R2 unmapped"); rd(41, "R2 misaligned"); rd(64, "R2 unmapped");
    rd(96, "R2 unmapped"); rd(8, "R2 unmapped"); rd(40, "R2 data0 intact");

    // R10 aux control
    step(1, 104, 8'hFF, 0, 0, 0, 0, "R10");
    rd(104, "R10 aux read");
    chk("R10 enables", {6'b0, buf_en, crc_en}, 8'h03);
    step(1, 104, 8'h02, 0, 0, 0, 0, "R10");
    chk("R10 enables", {6'b0, buf_en, crc_en}, 8'h02);

    // R3 start
    step(1, 16, 8'hCC, 0, 0, 0, 0, "R3 start");
    chk("R3 proto", {5'b0, proto}, 8'h03);
    chk("R3 pec", {7'b0, pec}, 8'h01);
    rd(16, "R3 ctl read");
    idle("R3 pulse end");
    // R4 start while busy
    step(1, 16, 8'h54, 0, 0, 0, 0, "R4 start busy");
    idle("R4");
    // R5 done
    step(0, 0, 0, 1, 0, 0, 0, "R5 done");
    // R8 sticky
    step(1, 0, 8'h00, 0, 0, 0, 0, "R8 write zero");
    step(1, 0, 8'h01, 0, 0, 0, 0, "R8 busy bit");
    step(1, 0, 8'h02, 0, 0, 0, 0, "R8 clear intr");

    // R6 errors
    step(1, 16, 8'h48, 0, 0, 0, 0, "R6 start");
    step(0, 0, 0, 1, 1, 0, 0, "R6 dev+done");
    step(1, 16, 8'h48, 0, 0, 0, 0, "R6 start");
    step(0, 0, 0, 0, 0, 1, 0, "R6 bus");
    // R7 byte done
    step(1, 16, 8'h54, 0, 0, 0, 0, "R7 start");
    step(0, 0, 0, 0, 0, 0, 1, "R7 byte");
    step(0, 0, 0, 1, 0, 0, 0, "R7 done");
    step(1, 0, 8'h04, 0, 0, 0, 0, "R8 single clear");
    step(1, 0, 8'hFF, 0, 0, 0, 0, "R8 clear all");

    // R9 kill
    step(1, 16, 8'h50, 0, 0, 0, 0, "R9 start");
    step(1, 16, 8'h12, 0, 0, 0, 0, "R9 kill set");
    idle("R9 kill effect");
    rd(16, "R9 ctl read");
    step(1, 16, 8'h00, 0, 0, 0, 0, "R9 kill clear");
    step(1, 0, 8'hFF, 0, 0, 0, 0, "R8 clear");

    // R11 idle events
    step(0, 0, 0, 1, 0, 0, 0, "R11 idle done");
    step(0, 0, 0, 0, 1, 1, 1, "R11 idle errs");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 9);
      d = 8'($urandom);
      if (r < 2) begin
        d = (d & 8'hBC) | 8'h40;
        if ($urandom_range(0, 7) == 0) d[1] = 1'b1;
        step(1, 16, d, 0, 0, 0, 0, "R3 R4 random start");
      end else if (r == 2) begin
        step(1, 16, d & 8'hBE, 0, 0, 0, 0, "R9 random ctl");
      end else if (r == 3) begin
        step(1, 0, d, 0, 0, 0, 0, "R8 random clear");
      end else begin
        step(0, 0, 0, $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
             $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0, "R5 R6 R7 R11 random");
      end
    end
    for (int n = 0; n < 30; n++) begin
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: step(1, 24, 8'($urandom), 0, 0, 0, 0, "R2 random");
        1: step(1, 32, 8'($urandom), 0, 0, 0, 0, "R2 random");
        2: step(1, 40, 8'($urandom), 0, 0, 0, 0, "R2 random");
        3: step(1, 48, 8'($urandom), 0, 0, 0, 0, "R2 random");
        default: step(1, 104, 8'($urandom), 0, 0, 0, 0, "R10 random");
      endcase
      rd(24, "R2 cmd"); rd(32, "R2 addr"); rd(40, "R2 d0"); rd(48, "R2 d1"); rd(104, "R10 aux");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule